// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is a single capture/compare channel that sits beside a free-running timer counter and is programmed over a narrow byte-wide register bus. It holds the channel value twice: a preload copy that the bus sees, and a shadow copy that the hardware uses. A control field picks the direction.

In input capture mode, a qualified edge strobe latches the counter into the channel. A flag records the event, and a second flag records a capture that arrived before the first one was serviced. In output compare mode, the shadow copy is compared against the counter, which gives an equal output and a greater-than output.

The value is twice the bus width, so software moves it one byte at a time. A lock on each access direction keeps hardware transfers from landing between the two halves:

- Reading the high byte starts an atomic read. Any capture that arrives during the read is parked in the shadow copy until the low byte has been read.
- Writing the high byte starts an atomic write. The compare transfer waits until the low byte has been written.

The register port is a plain one-cycle strobe interface. It has no handshake and no back-pressure: every strobe takes effect at the next clock edge, and read data is a combinational function of the address.

Top module: `ccc_channel`

## Requirements
- R1: After reset, the preload value, the shadow value, both flags, both access locks and the control field are all zero. The compare, interrupt and DMA outputs are low.
- R2: Byte addresses are 0 for the value low byte, 1 for the value high byte, 2 for control and 3 for status. `bus_rdata_o` always shows the addressed byte of the preload value, of the control field or of the status field. Writes to addresses 0 and 1 replace that byte of the preload value.
- R3: The control byte is laid out as follows: bits 1:0 select the mode, where 00 is output compare and any other value is input capture; bit 2 is preload enable; bit 3 is channel enable; bit 4 is interrupt enable; bit 5 is DMA enable. With capture mode selected and the channel enabled, a `capture_i` strobe latches `cnt_i` into the shadow copy and sets the capture flag (status bit 0). When the read lock is clear, the captured value reaches the preload copy at the same edge. With the channel disabled, `capture_i` is ignored.
- R4: A capture that arrives while the capture flag is already set also sets the over-capture flag (status bit 1).
- R5: Reading the value low byte clears the capture flag. A status write clears each flag whose written bit is 0 and leaves unchanged each flag whose written bit is 1. A capture in the same cycle as a clear leaves the flag set.
- R6: Reading the high byte sets the read lock, and reading the low byte clears it. While the lock is set, captures do not change the preload value. A held capture, which is the last one taken, appears in the preload value in the cycle after the low-byte read.
- R7: In compare mode with preload enable clear, the shadow copy follows the preload copy one cycle after each change. Writing the high byte sets the write lock, and writing the low byte clears it. While the lock is set, the shadow copy is held.
- R8: In compare mode with preload enable set, the shadow copy loads from the preload copy only on an `update_i` strobe. An `update_i` strobe that arrives while the write lock is set is lost.
- R9: In compare mode with the channel enabled, `cmp_eq_o` is high when `cnt_i` equals the shadow value, and `cmp_gt_o` is high when `cnt_i` is greater than it. Both outputs are low otherwise.
- R10: `irq_o` is the capture flag gated by interrupt enable. `dma_req_o` is the capture flag gated by DMA enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd_i | input | 1 | Read strobe; read side effects happen at the next edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed byte |
| cnt_i | input | 16 | Timer counter value |
| update_i | input | 1 | Update event strobe from the time base |
| capture_i | input | 1 | Qualified input edge strobe |
| cmp_eq_o | output | 1 | Counter equals shadow value |
| cmp_gt_o | output | 1 | Counter greater than shadow value |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | DMA request level |

## Verification
The bench sends captures into an open high-byte read and checks two things. The low byte must still match the value the high byte came from. The last held capture must surface exactly one cycle later. A design without the read lock would return a torn value, and one that dropped the parked capture would keep stale data.

The bench also pits captures against flag clears in the same cycle. A design with the wrong priority would lose an event.

It issues update strobes during a split write and during idle cycles with preload enable set. A design that transferred too early would compare against a half-written threshold or against a threshold that never took effect.

Random thresholds are checked one below, at and one above the counter, which exposes off-by-one errors in the comparator.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic       dma_en;
    logic       irq_en;
    logic       chan_en;
    logic       preload_en;
    logic [1:0] mode;
  } ccc_ctrl_t;

  localparam int CTRL_W = $bits(ccc_ctrl_t);
  localparam logic [1:0] MODE_COMPARE = 2'b00;
endpackage

// File: rtl/ccc_bus_port.sv
module ccc_bus_port
  import ccc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [VAL_W-1:0]  preload,
  input  logic              flag,
  input  logic              ovf,
  output logic [BUS_W-1:0]  rdata,
  output logic              rd_lo,
  output logic              rd_hi,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_stat,
  output logic              rip_q,
  output logic              wip_q,
  output ccc_ctrl_t         ctrl_q
);
  assign rd_lo   = rd && addr == ADDR_LO;
  assign rd_hi   = rd && addr == ADDR_HI;
  assign wr_lo   = wr && addr == ADDR_LO;
  assign wr_hi   = wr && addr == ADDR_HI;
  assign wr_stat = wr && addr == ADDR_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rip_q  <= 1'b0;
      wip_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (rd_hi) rip_q <= 1'b1;
      else if (rd_lo) rip_q <= 1'b0;
      if (wr_hi) wip_q <= 1'b1;
      else if (wr_lo) wip_q <= 1'b0;
      if (wr && addr == ADDR_CTRL) ctrl_q <= ccc_ctrl_t'(ctrl_wdata);
    end
  end

  always_comb begin
    case (addr)
      ADDR_LO:   rdata = preload[BUS_W-1:0];
      ADDR_HI:   rdata = preload[VAL_W-1:BUS_W];
      ADDR_CTRL: rdata = BUS_W'(ctrl_q);
      default:   rdata = BUS_W'({ovf, flag});
    endcase
  end

  AST_RIP_SET_BY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rip_q); // R6
  AST_RIP_CLR_BY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !rip_q); // R6
  AST_WIP_CLR_BY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !wip_q); // R7
endmodule

// File: rtl/ccc_value_regs.sv
module ccc_value_regs #(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             rd_hi,
  input  logic             rip_q,
  input  logic             wip_q,
  input  logic [BUS_W-1:0] wdata,
  input  logic [VAL_W-1:0] cnt,
  input  logic             cap_stb,
  input  logic             out_mode,
  input  logic             preload_en,
  input  logic             update,
  output logic [VAL_W-1:0] preload,
  output logic [VAL_W-1:0] shadow
);
  logic pend_q;
  logic rd_lock, wr_lock, cmp_xfer;

  // A high-byte access in the current cycle locks as strongly as the latch.
  assign rd_lock  = rip_q | rd_hi;
  assign wr_lock  = wip_q | wr_hi;
  assign cmp_xfer = out_mode & ~wr_lock & (preload_en ? update : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload <= '0;
      shadow  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_lo) preload[BUS_W-1:0]     <= wdata;
      if (wr_hi) preload[VAL_W-1:BUS_W] <= wdata;
      // Capture-side transfers override a bus write landing in the same cycle.
      if (cap_stb) begin
        shadow <= cnt;
        if (rd_lock) begin
          pend_q <= 1'b1;
        end else begin
          preload <= cnt;
          pend_q  <= 1'b0;
        end
      end else if (pend_q && !rd_lock) begin
        preload <= shadow;
        pend_q  <= 1'b0;
      end else if (cmp_xfer) begin
        shadow <= preload;
      end
    end
  end

  AST_READ_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (rip_q && !wr_lo && !wr_hi) |=> $stable(preload)); // R6
  AST_PENDING_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_lock && !cap_stb) |=> preload == $past(shadow)); // R6
  AST_WRITE_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && !cap_stb) |=> $stable(shadow)); // R7
  AST_WAIT_FOR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && preload_en && !update && !cap_stb) |=> $stable(shadow)); // R8
endmodule

// File: rtl/ccc_flags.sv
module ccc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_stb,
  input  logic       rd_lo,
  input  logic       wr_stat,
  input  logic [1:0] stat_wdata,
  output logic       flag_q,
  output logic       ovf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cap_stb) flag_q <= 1'b1;
      else if (rd_lo || (wr_stat && !stat_wdata[0])) flag_q <= 1'b0;
      if (cap_stb && flag_q) ovf_q <= 1'b1;
      else if (wr_stat && !stat_wdata[1]) ovf_q <= 1'b0;
    end
  end

  AST_CAP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> flag_q); // R3
  AST_OVF_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && flag_q) |=> ovf_q); // R4
  AST_OVF_NEEDS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(cap_stb && flag_q)); // R4
endmodule

// File: rtl/ccc_compare.sv
module ccc_compare #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [VAL_W-1:0] cnt,
  input  logic [VAL_W-1:0] shadow,
  output logic             eq,
  output logic             gt
);
  assign eq = active && (cnt == shadow);
  assign gt = active && (cnt > shadow);

  AST_EQ_GT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eq && gt)); // R9
endmodule

// File: rtl/ccc_channel.sv
module ccc_channel
  import ccc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic             update_i,
  input  logic             capture_i,
  output logic             cmp_eq_o,
  output logic             cmp_gt_o,
  output logic             irq_o,
  output logic             dma_req_o
);
  ccc_ctrl_t        ctrl_q;
  logic             rd_lo, rd_hi, wr_lo, wr_hi, wr_stat, rip_q, wip_q;
  logic             flag_q, ovf_q, cap_stb, out_mode;
  logic [VAL_W-1:0] preload, shadow;

  assign out_mode = ctrl_q.mode == MODE_COMPARE;
  assign cap_stb  = capture_i && ctrl_q.chan_en && !out_mode;

  ccc_bus_port #(.BUS_W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd_i), .wr(bus_wr_i), .addr(bus_addr_i),
    .ctrl_wdata(bus_wdata_i[CTRL_W-1:0]), .preload(preload), .flag(flag_q),
    .ovf(ovf_q), .rdata(bus_rdata_o), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_stat(wr_stat), .rip_q(rip_q),
    .wip_q(wip_q), .ctrl_q(ctrl_q)
  );

  ccc_value_regs #(.BUS_W(BUS_W)) u_val (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_hi(rd_hi),
    .rip_q(rip_q), .wip_q(wip_q), .wdata(bus_wdata_i), .cnt(cnt_i),
    .cap_stb(cap_stb), .out_mode(out_mode), .preload_en(ctrl_q.preload_en),
    .update(update_i), .preload(preload), .shadow(shadow)
  );

  ccc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .rd_lo(rd_lo),
    .wr_stat(wr_stat), .stat_wdata(bus_wdata_i[1:0]),
    .flag_q(flag_q), .ovf_q(ovf_q)
  );

  ccc_compare #(.VAL_W(VAL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(out_mode && ctrl_q.chan_en),
    .cnt(cnt_i), .shadow(shadow), .eq(cmp_eq_o), .gt(cmp_gt_o)
  );

  assign irq_o     = flag_q && ctrl_q.irq_en;
  assign dma_req_o = flag_q && ctrl_q.dma_en;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || dma_req_o) |-> u_flags.flag_q); // R10
endmodule

// File: tb/ccc_channel_test.sv
module ccc_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 0, wr = 0, upd = 0, cap = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] cnt = 0;
  logic eq, gt, irq, dma;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  ccc_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cnt_i(cnt), .update_i(upd),
    .capture_i(cap), .cmp_eq_o(eq), .cmp_gt_o(gt), .irq_o(irq), .dma_req_o(dma)
  );

  function automatic logic [1:0] exp_cmp(logic [15:0] c, logic [15:0] t);
    return {c > t, c == t};
  endfunction
  function automatic logic [7:0] exp_stat(int n);
    return {6'd0, n > 1, n > 0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic cyc(); @(posedge clk); #2; endtask
  task automatic bwr(logic [1:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; cyc(); wr = 0;
  endtask
  task automatic brd(logic [1:0] a, output logic [7:0] d);
    rd = 1; addr = a; #1 d = rdata; cyc(); rd = 0;
  endtask
  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    brd(2'd1, h); brd(2'd0, l); v = {h, l};
  endtask
  task automatic peek(logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask
  task automatic capt(logic [15:0] v);
    cnt = v; cap = 1; cyc(); cap = 0;
  endtask
  task automatic cmp_at(string req, logic [15:0] c, logic [15:0] t);
    cnt = c; #1 chk(req, {eq, gt}, {exp_cmp(c, t)[0], exp_cmp(c, t)[1]});
  endtask

  initial begin
    #2000000;
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    void'($urandom(32'd1234));
    #23 rst_n = 1; cyc();
    // R1 reset state
    peek(2'd0, b); chk("R1 lo", b, 0);
    peek(2'd1, b); chk("R1 hi", b, 0);
    peek(2'd3, b); chk("R1 status", b, 0);
    peek(2'd2, b); chk("R1 ctrl", b, 0);
    chk("R1 outputs", {eq, gt, irq, dma}, 0);
    // R2 byte access
    bwr(2'd1, 8'h12); bwr(2'd0, 8'h34); rd16(v); chk("R2 value", v, 16'h1234);
    // R3 disabled channel ignores capture
    bwr(2'd2, 8'h01); capt(16'h5555); rd16(v); chk("R3 disabled value", v, 16'h1234);
    peek(2'd3, b); chk("R3 disabled flag", b, 0);
    // R3 capture
    bwr(2'd2, 8'h09); capt(16'hABCD);
    peek(2'd3, b); chk("R3 flag", b, exp_stat(1));
    rd16(v); chk("R3 value", v, 16'hABCD);
    peek(2'd3, b); chk("R5 low read clears", b, 0);
    // R4 over-capture, R5 selective clear
    capt(16'h0001); capt(16'h0002);
    peek(2'd3, b); chk("R4 status", b, exp_stat(2));
    bwr(2'd3, 8'h02); peek(2'd3, b); chk("R5 keep ovf", b, 8'h02);
    bwr(2'd3, 8'h00); peek(2'd3, b); chk("R5 clear all", b, 0);
    // R5 capture beats low read and status clear
    cnt = 16'h7777; cap = 1; rd = 1; addr = 2'd0; cyc(); cap = 0; rd = 0;
    peek(2'd3, b); chk("R5 cap vs read", b[0], 1);
    cnt = 16'h7778; cap = 1; wr = 1; addr = 2'd3; wdata = 0; cyc(); cap = 0; wr = 0;
    peek(2'd3, b); chk("R5 cap vs write", b[0], 1);
    // R6 read lock
    bwr(2'd3, 8'h00); capt(16'h1111);
    brd(2'd1, b); chk("R6 hi", b, 8'h11);
    capt(16'h2222); capt(16'h3333);
    brd(2'd0, b); chk("R6 lo untorn", b, 8'h11);
    peek(2'd1, b); chk("R6 still held", b, 8'h11);
    cyc(); peek(2'd1, b); chk("R6 released hi", b, 8'h33);
    peek(2'd0, b); chk("R6 released lo", b, 8'h33);
    // R10 request levels
    bwr(2'd3, 8'h00); bwr(2'd2, 8'h19); capt(16'h3333);
    chk("R10 irq", {irq, dma}, 2'b10);
    bwr(2'd2, 8'h29); chk("R10 dma", {irq, dma}, 2'b01);
    brd(2'd0, b); chk("R10 cleared", {irq, dma}, 2'b00);
    // R7 compare, no preload
    bwr(2'd2, 8'h08); cyc();
    cmp_at("R9 initial", 16'h3333, 16'h3333);
    bwr(2'd1, 8'h40); cmp_at("R7 held after hi", 16'h3333, 16'h3333);
    bwr(2'd0, 8'h00); cmp_at("R7 held at lo", 16'h3333, 16'h3333);
    cyc();
    cmp_at("R7 eq", 16'h4000, 16'h4000);
    cmp_at("R9 gt", 16'h4001, 16'h4000);
    cmp_at("R9 lt", 16'h3FFF, 16'h4000);
    // R8 preload enabled
    bwr(2'd2, 8'h0C); bwr(2'd1, 8'h50); bwr(2'd0, 8'h00); cyc(); cyc();
    cmp_at("R8 no update", 16'h4000, 16'h4000);
    upd = 1; cyc(); upd = 0; cmp_at("R8 update", 16'h5000, 16'h5000);
    bwr(2'd1, 8'h60); upd = 1; cyc(); upd = 0;
    cmp_at("R8 update locked", 16'h5000, 16'h5000);
    bwr(2'd0, 8'h00); upd = 1; cyc(); upd = 0;
    cmp_at("R8 update after", 16'h6000, 16'h6000);
    // R9 disabled channel
    bwr(2'd2, 8'h00); cnt = 16'h6000; #1 chk("R9 disabled", {eq, gt}, 0);
    // R7 R9 random thresholds
    bwr(2'd2, 8'h08);
    for (int i = 0; i < 60; i++) begin
      logic [15:0] t, c;
      t = 16'($urandom);
      bwr(2'd1, t[15:8]); bwr(2'd0, t[7:0]); cyc();
      case ($urandom % 4)
        0: c = t - 1;
        1: c = t;
        2: c = t + 1;
        default: c = 16'($urandom);
      endcase
      cmp_at("R9 random", c, t);
    end
    // R3 R4 random captures
    bwr(2'd2, 8'h09);
    for (int i = 0; i < 60; i++) begin
      logic [15:0] x;
      int n;
      bwr(2'd3, 8'h00);
      n = 1 + int'($urandom % 2);
      for (int k = 0; k < n; k++) begin
        x = 16'($urandom); capt(x);
      end
      peek(2'd3, b); chk("R4 random status", b, exp_stat(n));
      rd16(v); chk("R3 random value", v, x);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule